// File: doc/BRIEF.md
# Multisample Pixel Merge Engine

This block owns one interleaved share of a multisample framebuffer's pixels. For each pixel it keeps a depth and a color for every enabled subsample, plus one resolved color that can be displayed directly. An upstream rasterizer first loads the depth gradients of a triangle. It then streams fragments over a valid/ready port. Each fragment carries a pixel index, a 48-bit color, the depth at the pixel's central sample and a 16-bit coverage mask.

For each fragment the block reads the pixel from its internal synchronous RAM. It rebuilds the depth of every subsample from the central depth, the two gradients and that sample's offset on an 8x8 grid. It then runs a strict less-than depth test on each covered sample and writes the winners back. The resolved color is recomputed in the same operation, so a finished frame needs no separate resolve pass.

A fragment that covers the whole pixel and wins every test writes only the sample depths and the resolved color. It marks the pixel as uniform and leaves the per-sample colors alone. A later partial hit on that pixel first spreads the resolved color into the sample colors and then merges as usual. An optional mode turns the fragment alpha into a sample mask. A clear command resets the whole slice, and a read port returns any pixel's resolved color.

Top module: `msm_pixel_merge`

## Requirements
- R1: Per-sample depth is center_depth + dzdx*dx + dzdy*dy, with signed slopes taken from the last slope load before the fragment was accepted. The result is clamped to the range 0 to 2^32-1.
- R2: A covered sample passes only if its rebuilt depth is strictly less than the stored depth. A passing sample takes the fragment color and the rebuilt depth. A failing sample keeps both stored values.
- R3: When at least one sample passes on a partial update, the resolved color is rewritten in the same operation. Each 12-bit component becomes the sum of that component over the NSAMP sample colors, shifted right by log2(NSAMP) and truncated. Colors are packed {R,G,B,A}, with A in bits [11:0].
- R4: When every one of the NSAMP samples passes, the sample depths and the resolved color are written, and the resolved color becomes the fragment color. The pixel is marked uniform and its sample colors are left unchanged.
- R5: A partial update on a uniform pixel treats all sample colors as equal to the resolved color before merging. After the merge the pixel is no longer uniform.
- R6: With alpha-to-mask enabled, sample i stays covered only if the alpha exceeds bitrev(i) << (12 - log2(NSAMP)). The bit reversal is taken over log2(NSAMP) bits. This result is ANDed with the coverage mask.
- R7: Only coverage bits [NSAMP-1:0] take part. Fragments with no covered low bits change nothing.
- R8: A clear command taken while idle sets every sample depth to all ones. It sets every sample color and resolved color to the clear color, and it drops every uniform mark. frag_ready stays low for exactly NPIX cycles after the clear is taken.
- R9: After reset frag_ready is high. A fragment is taken on frag_valid && frag_ready, and frag_ready is low in the following cycle.
- R10: disp_color shows the resolved color of the pixel at disp_addr one clock later.
- R11: Sample i's position is samp_pos[8i+7:8i] = {dy, dx}. Each is a signed 4-bit value in eighths of a pixel, measured from the central sample. The field is changed only while no fragment is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slope_ld | input | 1 | Load the triangle depth gradients |
| slope_dx | input | SLW | Signed depth change per 1/8 pixel in X |
| slope_dy | input | SLW | Signed depth change per 1/8 pixel in Y |
| samp_pos | input | NSAMP*8 | Per-sample {dy, dx} grid offsets |
| a2m_en | input | 1 | Alpha-to-mask enable, captured with each fragment |
| clr_start | input | 1 | Start a clear of the whole slice |
| clr_color | input | 48 | Clear color |
| frag_valid | input | 1 | Fragment present |
| frag_ready | output | 1 | Fragment can be taken |
| frag_addr | input | AW | Pixel index inside the slice |
| frag_color | input | 48 | Fragment color {R,G,B,A} |
| frag_z | input | 32 | Depth at the central sample |
| frag_cov | input | 16 | Coverage mask |
| disp_addr | input | AW | Pixel to read out |
| disp_color | output | 48 | Resolved color of that pixel |

## Verification
The bench builds the block with four samples and four pixels, so every pixel is revisited dozens of times. Depth collisions, uniform-mark transitions and repeated partial hits all occur in one short run. With four samples the alpha-to-mask thresholds fall on quarter steps that can be reached one by one, and the grid offsets reach both clamp limits. A second clear followed by a new sample layout shows that the position field is honoured after it changes between frames.

// File: rtl/msm_pkg.sv
// Shared widths and helpers for the multisample pixel merge engine.
// Assumes colors are four 12-bit components packed {R,G,B,A}.
package msm_pkg;
    localparam int CW = 12;
    localparam int PCW = 4 * CW;
    localparam int ZW = 32;

    // Reverse the low w bits of v; used to spread alpha thresholds over samples.
    function automatic int unsigned bit_rev(input int unsigned v, input int unsigned w);
        int unsigned r;
        r = 0;
        for (int unsigned b = 0; b < w; b++)
            r = r | (((v >> b) & 1) << (w - 1 - b));
        return r;
    endfunction
endpackage

// File: rtl/msm_depth_gen.sv
// Rebuilds every subsample depth from the central depth and the two gradients.
// Assumes offsets are signed eighths of a pixel; the result saturates to 32 bits.
module msm_depth_gen #(
    parameter int NSAMP = 4,
    parameter int SLW   = 16
) (
    input  logic [msm_pkg::ZW-1:0]       zc,
    input  logic [SLW-1:0]               sx,
    input  logic [SLW-1:0]               sy,
    input  logic [NSAMP*8-1:0]           pos,
    output logic [NSAMP*msm_pkg::ZW-1:0] zs
);
    import msm_pkg::*;
    localparam int SW = ZW + SLW + 6;

    for (genvar i = 0; i < NSAMP; i++) begin : g_samp
        logic signed [3:0]    dx, dy;
        logic signed [SW-1:0] sum;
        logic [ZW-1:0]        z;
        assign dx = $signed(pos[i*8 +: 4]);
        assign dy = $signed(pos[i*8+4 +: 4]);
        // Plane evaluation at this sample followed by saturation.
        always_comb begin
            sum = SW'($signed({1'b0, zc})) + SW'($signed(sx)) * SW'(dx)
                + SW'($signed(sy)) * SW'(dy);
            if (sum[SW-1])             z = '0;
            else if (|sum[SW-2:ZW])    z = '1;
            else                       z = sum[ZW-1:0];
        end
        assign zs[i*ZW +: ZW] = z;
    end
endmodule

// File: rtl/msm_cov_mask.sv
// Forms the effective sample mask from coverage and optional alpha-to-mask.
// Assumes NSAMP is a power of two between 4 and 16.
module msm_cov_mask #(
    parameter int NSAMP = 4
) (
    input  logic [NSAMP-1:0]       cov,
    input  logic [msm_pkg::CW-1:0] alpha,
    input  logic                   a2m,
    output logic [NSAMP-1:0]       mask
);
    import msm_pkg::*;
    localparam int LOG2N = $clog2(NSAMP);

    for (genvar i = 0; i < NSAMP; i++) begin : g_bit
        localparam logic [CW-1:0] THR = CW'(bit_rev(i, LOG2N) << (CW - LOG2N));
        // A sample survives when covered and, in alpha mode, above its threshold.
        assign mask[i] = cov[i] & (~a2m | (alpha > THR));
    end
endmodule

// File: rtl/msm_resolve.sv
// Averages NSAMP packed colors per component with a truncating shift.
// Assumes NSAMP is a power of two.
module msm_resolve #(
    parameter int NSAMP = 4
) (
    input  logic [NSAMP*msm_pkg::PCW-1:0] cols,
    output logic [msm_pkg::PCW-1:0]       avg
);
    import msm_pkg::*;
    localparam int LOG2N = $clog2(NSAMP);
    localparam int SUMW  = CW + LOG2N;

    for (genvar c = 0; c < 4; c++) begin : g_comp
        logic [SUMW-1:0] acc;
        // Component sum over all enabled samples.
        always_comb begin
            acc = '0;
            for (int s = 0; s < NSAMP; s++)
                acc = acc + SUMW'(cols[s*PCW + c*CW +: CW]);
        end
        assign avg[c*CW +: CW] = acc[SUMW-1:LOG2N];
    end
endmodule

// File: rtl/msm_pixel_merge.sv
// Merges fragments into one slice of a multisample framebuffer kept in on-block RAM.
// Assumes NPIX is a power of two and samp_pos only changes with no fragment in flight.
// One fragment takes two cycles: read the pixel, then merge and write it back.
module msm_pixel_merge #(
    parameter int NSAMP = 4,
    parameter int NPIX  = 16,
    parameter int SLW   = 16,
    localparam int AW   = $clog2(NPIX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               slope_ld,
    input  logic [SLW-1:0]     slope_dx,
    input  logic [SLW-1:0]     slope_dy,
    input  logic [NSAMP*8-1:0] samp_pos,
    input  logic               a2m_en,
    input  logic               clr_start,
    input  logic [47:0]        clr_color,
    input  logic               frag_valid,
    output logic               frag_ready,
    input  logic [AW-1:0]      frag_addr,
    input  logic [47:0]        frag_color,
    input  logic [31:0]        frag_z,
    input  logic [15:0]        frag_cov,
    input  logic [AW-1:0]      disp_addr,
    output logic [47:0]        disp_color
);
    import msm_pkg::*;

    typedef enum logic [1:0] {ST_IDLE, ST_MERGE, ST_CLEAR} state_t;

    state_t                 state;
    logic [AW-1:0]          clr_idx;
    logic [PCW-1:0]         clr_col_q;
    logic [SLW-1:0]         sx_q, sy_q, fsx_q, fsy_q;
    logic [AW-1:0]          addr_q;
    logic [PCW-1:0]         color_q;
    logic [ZW-1:0]          zc_q;
    logic [NSAMP-1:0]       cov_q;
    logic                   a2m_q;
    logic [NPIX-1:0]        tag_q;

    logic [NSAMP*PCW-1:0]   col_mem [NPIX];
    logic [NSAMP*ZW-1:0]    z_mem   [NPIX];
    logic [PCW-1:0]         dsp_mem [NPIX];
    logic [NSAMP*PCW-1:0]   col_rd;
    logic [NSAMP*ZW-1:0]    z_rd;
    logic [PCW-1:0]         dsp_rd;
    logic [PCW-1:0]         disp_q;

    logic                   acc, in_idle, in_merge, tag_cur;
    logic [NSAMP-1:0]       mask_w, pass;
    logic [NSAMP*ZW-1:0]    zs_all, newz;
    logic [NSAMP*PCW-1:0]   newc;
    logic [PCW-1:0]         avg;
    logic                   all_pass, any_pass;
    logic [CW-1:0]          alpha_q;

    if (NSAMP < 16) begin : g_cov_unused
        logic cov_hi_unused;
        assign cov_hi_unused = ^frag_cov[15:NSAMP];
    end

    assign in_idle    = (state == ST_IDLE);
    assign in_merge   = (state == ST_MERGE);
    assign frag_ready = rst_n && in_idle && !clr_start;
    assign acc        = frag_valid && frag_ready;
    assign tag_cur    = tag_q[addr_q];
    assign alpha_q    = color_q[CW-1:0];
    assign disp_color = disp_q;

    // Control state, clear sweep counter and uniform-pixel marks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            clr_idx <= '0;
            tag_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (clr_start) begin
                        state   <= ST_CLEAR;
                        clr_idx <= '0;
                        tag_q   <= '0;
                    end else if (frag_valid) begin
                        state <= ST_MERGE;
                    end
                end
                ST_MERGE: begin
                    state <= ST_IDLE;
                    if (all_pass)      tag_q[addr_q] <= 1'b1;
                    else if (any_pass) tag_q[addr_q] <= 1'b0;
                end
                default: begin
                    clr_idx <= clr_idx + AW'(1);
                    if (clr_idx == AW'(NPIX - 1)) state <= ST_IDLE;
                end
            endcase
        end
    end

    // Gradient registers and the captured fragment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sx_q <= '0;  sy_q <= '0;  fsx_q <= '0;  fsy_q <= '0;
            addr_q <= '0; color_q <= '0; zc_q <= '0; cov_q <= '0; a2m_q <= 1'b0;
            clr_col_q <= '0;
        end else begin
            if (slope_ld) begin
                sx_q <= slope_dx;
                sy_q <= slope_dy;
            end
            if (clr_start && in_idle) clr_col_q <= clr_color;
            if (acc) begin
                addr_q <= frag_addr;  color_q <= frag_color;  zc_q <= frag_z;
                cov_q  <= frag_cov[NSAMP-1:0];  a2m_q <= a2m_en;
                fsx_q  <= sx_q;  fsy_q <= sy_q;
            end
        end
    end

    msm_depth_gen #(.NSAMP(NSAMP), .SLW(SLW)) u_depth (
        .zc(zc_q), .sx(fsx_q), .sy(fsy_q), .pos(samp_pos), .zs(zs_all)
    );

    msm_cov_mask #(.NSAMP(NSAMP)) u_mask (
        .cov(cov_q), .alpha(alpha_q), .a2m(a2m_q), .mask(mask_w)
    );

    for (genvar s = 0; s < NSAMP; s++) begin : g_merge
        logic [PCW-1:0] oldc;
        logic [ZW-1:0]  zn, zo;
        assign oldc = tag_cur ? dsp_rd : col_rd[s*PCW +: PCW];
        assign zn   = zs_all[s*ZW +: ZW];
        assign zo   = z_rd[s*ZW +: ZW];
        assign pass[s] = mask_w[s] && (zn < zo);
        assign newc[s*PCW +: PCW] = pass[s] ? color_q : oldc;
        assign newz[s*ZW +: ZW]   = pass[s] ? zn : zo;
    end

    assign all_pass = &pass;
    assign any_pass = |pass;

    msm_resolve #(.NSAMP(NSAMP)) u_resolve (.cols(newc), .avg(avg));

    // Pixel RAM: read on accept, write back on merge or clear, readout port.
    always_ff @(posedge clk) begin
        if (acc) begin
            col_rd <= col_mem[frag_addr];
            z_rd   <= z_mem[frag_addr];
            dsp_rd <= dsp_mem[frag_addr];
        end
        if (state == ST_CLEAR) begin
            col_mem[clr_idx] <= {NSAMP{clr_col_q}};
            z_mem[clr_idx]   <= '1;
            dsp_mem[clr_idx] <= clr_col_q;
        end else if (in_merge && any_pass) begin
            z_mem[addr_q] <= newz;
            if (all_pass) begin
                dsp_mem[addr_q] <= color_q;
            end else begin
                col_mem[addr_q] <= newc;
                dsp_mem[addr_q] <= avg;
            end
        end
        disp_q <= dsp_mem[disp_addr];
    end
endmodule

// File: rtl/msm_merge_checker.sv
// Protocol and mask properties of the pixel merge engine, bound to the top module.
// Assumes it sees the top's ports plus its stage flags and captured fragment fields.
module msm_merge_checker #(
    parameter int NSAMP = 4,
    parameter int AW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frag_valid,
    input logic             frag_ready,
    input logic             clr_start,
    input logic             in_idle,
    input logic             in_merge,
    input logic             a2m_q,
    input logic [11:0]      alpha_q,
    input logic [NSAMP-1:0] cov_lo,
    input logic [NSAMP-1:0] merge_mask,
    input logic [AW-1:0]    disp_addr,
    input logic [47:0]      disp_color
);
    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (frag_valid && frag_ready) |=> !frag_ready) else $error("ready held after accept"); // R9

    AST_CLEAR_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_start && in_idle) |=> !frag_ready) else $error("ready during clear"); // R8

    AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        in_merge |-> ((merge_mask & ~cov_lo) == '0)) else $error("mask outside coverage"); // R7

    AST_A2M_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_merge && a2m_q && alpha_q == 12'd0) |-> (merge_mask == '0)) else $error("zero alpha kept samples"); // R6

    AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(frag_ready) && $past(frag_ready, 2) && $past(disp_addr) == $past(disp_addr, 2))
        |-> $stable(disp_color)) else $error("readout moved without a write"); // R10
endmodule

bind msm_pixel_merge msm_merge_checker #(.NSAMP(NSAMP), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .frag_valid(frag_valid), .frag_ready(frag_ready),
    .clr_start(clr_start), .in_idle(in_idle), .in_merge(in_merge), .a2m_q(a2m_q),
    .alpha_q(alpha_q), .cov_lo(cov_q), .merge_mask(mask_w),
    .disp_addr(disp_addr), .disp_color(disp_color)
);

// File: tb/tb_msm_pixel_merge.sv
// Bench for the pixel merge engine: four samples, four pixels, directed and swept fragments
// checked against an arithmetic model of the requirements.
module tb_msm_pixel_merge;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int NP = 4;
    localparam int AWB = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slope_ld = 1'b0;
    logic [15:0] slope_dx = '0, slope_dy = '0;
    logic [NS*8-1:0] samp_pos = '0;
    logic a2m_en = 1'b0;
    logic clr_start = 1'b0;
    logic [47:0] clr_color = '0;
    logic frag_valid = 1'b0;
    logic frag_ready;
    logic [AWB-1:0] frag_addr = '0;
    logic [47:0] frag_color = '0;
    logic [31:0] frag_z = '0;
    logic [15:0] frag_cov = '0;
    logic [AWB-1:0] disp_addr = '0;
    logic [47:0] disp_color;

    msm_pixel_merge #(.NSAMP(NS), .NPIX(NP), .SLW(16)) dut (
        .clk(clk), .rst_n(rst_n), .slope_ld(slope_ld), .slope_dx(slope_dx),
        .slope_dy(slope_dy), .samp_pos(samp_pos), .a2m_en(a2m_en),
        .clr_start(clr_start), .clr_color(clr_color), .frag_valid(frag_valid),
        .frag_ready(frag_ready), .frag_addr(frag_addr), .frag_color(frag_color),
        .frag_z(frag_z), .frag_cov(frag_cov), .disp_addr(disp_addr),
        .disp_color(disp_color)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    // Model state.
    logic [31:0] mz [NP][NS];
    logic [47:0] mc [NP][NS];
    logic [47:0] md [NP];
    bit          mt [NP];
    int          mdx [NS], mdy [NS];
    int          rank [NS] = '{0, 2, 1, 3};

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rnd(output logic [31:0] r);
        seed = seed * 32'd1664525 + 32'd1013904223;
        r = seed;
    endtask

    task automatic set_pos(input int x0, input int y0, input int x1, input int y1,
                           input int x2, input int y2, input int x3, input int y3);
        int xs [NS], ys [NS];
        xs = '{x0, x1, x2, x3};
        ys = '{y0, y1, y2, y3};
        for (int i = 0; i < NS; i++) begin
            mdx[i] = xs[i];
            mdy[i] = ys[i];
            samp_pos[i*8 +: 4]   = 4'(xs[i]);
            samp_pos[i*8+4 +: 4] = 4'(ys[i]);
        end
    endtask

    task automatic model_frag(input int a, input logic [47:0] col, input logic [31:0] zc,
                              input logic [15:0] cov, input int sx, input int sy, input bit a2m);
        logic [31:0] zs [NS];
        logic [NS-1:0] p;
        longint v;
        int sum;
        for (int i = 0; i < NS; i++) begin
            v = longint'(zc) + longint'(sx) * mdx[i] + longint'(sy) * mdy[i];
            if (v < 0) zs[i] = 32'h0;
            else if (v > 64'h0000_0000_FFFF_FFFF) zs[i] = 32'hFFFF_FFFF;
            else zs[i] = v[31:0];
            p[i] = cov[i] && (!a2m || int'(col[11:0]) > rank[i] * 1024) && (zs[i] < mz[a][i]);
        end
        if (&p) begin
            for (int i = 0; i < NS; i++) mz[a][i] = zs[i];
            md[a] = col;
            mt[a] = 1'b1;
        end else if (|p) begin
            if (mt[a]) for (int i = 0; i < NS; i++) mc[a][i] = md[a];
            mt[a] = 1'b0;
            for (int i = 0; i < NS; i++) if (p[i]) begin
                mc[a][i] = col;
                mz[a][i] = zs[i];
            end
            for (int c = 0; c < 4; c++) begin
                sum = 0;
                for (int i = 0; i < NS; i++) sum += int'(mc[a][i][c*12 +: 12]);
                md[a][c*12 +: 12] = 12'(sum >> 2);
            end
        end
    endtask

    task automatic read_disp(input int a, output logic [47:0] val);
        @(negedge clk);
        disp_addr = AWB'(a);
        @(posedge clk);
        @(negedge clk);
        val = disp_color;
    endtask

    task automatic do_clear(input logic [47:0] c);
        int cnt;
        logic [47:0] val;
        @(negedge clk);
        clr_start = 1'b1;
        clr_color = c;
        @(posedge clk);
        @(negedge clk);
        clr_start = 1'b0;
        cnt = 0;
        while (!frag_ready) begin
            cnt++;
            @(negedge clk);
        end
        check("R8 clear stall length", 48'(cnt), 48'(NP));
        for (int a = 0; a < NP; a++) begin
            for (int i = 0; i < NS; i++) begin
                mz[a][i] = 32'hFFFF_FFFF;
                mc[a][i] = c;
            end
            md[a] = c;
            mt[a] = 1'b0;
            read_disp(a, val);
            check("R8 cleared pixel", val, c);
        end
    endtask

    task automatic do_frag(input string req, input int a, input logic [47:0] col,
                           input logic [31:0] zc, input logic [15:0] cov,
                           input int sx, input int sy, input bit a2m);
        logic [47:0] val;
        @(negedge clk);
        slope_ld = 1'b1;
        slope_dx = 16'(sx);
        slope_dy = 16'(sy);
        @(posedge clk);
        @(negedge clk);
        slope_ld = 1'b0;
        slope_dx = 16'h7FFF;
        slope_dy = 16'h8000;
        frag_valid = 1'b1;
        frag_addr = AWB'(a);
        frag_color = col;
        frag_z = zc;
        frag_cov = cov;
        a2m_en = a2m;
        while (!frag_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        frag_valid = 1'b0;
        a2m_en = 1'b0;
        check("R9 ready low after accept", 48'(frag_ready), 48'h0);
        @(posedge clk);
        model_frag(a, col, zc, cov, sx, sy, a2m);
        read_disp(a, val);
        check(req, val, md[a]);
    endtask

    task automatic sweep(input string req, input int n);
        logic [31:0] r0, r1, r2, r3;
        logic [15:0] cov;
        for (int k = 0; k < n; k++) begin
            rnd(r0); rnd(r1); rnd(r2); rnd(r3);
            cov = (r3[1:0] == 2'd0) ? (r0[15:0] | 16'h000F) : r0[31:16];
            do_frag(req, int'(r3[5:4]), {r1, r2[15:0]}, 32'd20000 + (r2 % 32'd20000), cov,
                    int'(r3[13:8] % 6'd41) - 20, int'(r3[21:16] % 6'd41) - 20,
                    r3[27:25] == 3'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        set_pos(0, 0, 3, -2, -4, 1, 2, 3);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 ready after reset", 48'(frag_ready), 48'h1);

        do_clear(48'h111_222_333_444);

        // R4: full cover, every test passes.
        do_frag("R4 full cover resolved", 0, 48'hA00_B00_C00_FFF, 32'd1000, 16'h000F, 0, 0, 1'b0);
        // R5: partial hit on a uniform pixel spreads the resolved color first.
        do_frag("R5 expand then merge", 0, 48'h400_800_C00_100, 32'd500, 16'h0001, 0, 0, 1'b0);
        // R2: farther fragment loses the strict test.
        do_frag("R2 farther rejected", 0, 48'hFFF_FFF_FFF_FFF, 32'd2000, 16'h0002, 0, 0, 1'b0);
        // R2: equal depth loses as well.
        do_frag("R2 equal depth rejected", 0, 48'h123_123_123_123, 32'd1000, 16'h0004, 0, 0, 1'b0);
        // R1: upper clamp on samples with positive X offset.
        do_frag("R1 upper clamp", 1, 48'h0F0_0F0_0F0_0F0, 32'hFFFF_FFF0, 16'h000F, 100, 0, 1'b0);
        // R1: lower clamp, then a zero-depth fragment only wins where depth is above zero.
        do_frag("R1 lower clamp", 2, 48'h300_300_300_300, 32'd10, 16'h000F, -100, 0, 1'b0);
        do_frag("R1 clamped depth stored", 2, 48'hC00_C00_C00_C00, 32'd0, 16'h000F, 0, 0, 1'b0);
        // R6: alpha-to-mask thresholds.
        do_frag("R6 zero alpha", 3, 48'h777_777_777_000, 32'd100, 16'h000F, 0, 0, 1'b1);
        do_frag("R6 mid alpha", 3, 48'h777_666_555_5DC, 32'd100, 16'h000F, 0, 0, 1'b1);
        do_frag("R6 full alpha", 3, 48'h222_333_444_FFF, 32'd50, 16'h000F, 0, 0, 1'b1);
        // R7: only high coverage bits set.
        do_frag("R7 high bits ignored", 1, 48'hEEE_EEE_EEE_EEE, 32'd0, 16'hFFF0, 0, 0, 1'b0);

        sweep("R3 swept merge", 150);

        // R11: new sample layout between frames.
        set_pos(0, 0, -1, -1, 1, -3, -3, 3);
        do_clear(48'h0AB_0CD_0EF_012);
        do_frag("R11 new layout", 0, 48'h800_800_800_800, 32'd30000, 16'h0003, 7, -5, 1'b0);
        sweep("R11 swept new layout", 60);

        begin
            logic [47:0] v1;
            read_disp(0, v1);
            check("R10 readout", v1, md[0]);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule